// File: doc/BRIEF.md
# Load-Use Hazard Stall Detector

This block sits in the decode stage of a five-stage in-order pipeline. A load fetches its result from memory one stage later than an ALU result is ready. If the instruction right behind the load needs that register as an operand, forwarding cannot supply it in time. The block compares the load's destination register against the source registers of the instruction now being decoded. On a match it asks for a one-cycle stall: the program counter and the fetch/decode register keep their values, and a bubble goes into the decode/execute register.

Both pipeline registers carry the full 32-bit instruction word, and the block slices out the register fields itself. Three opcode-class inputs come from the decoder. They say whether the instruction in execute is a load, and whether the instruction in decode actually reads its first and second source fields. A stall request lasts one cycle. A small internal flag stops the request from repeating in the next cycle, even if the surrounding logic has not yet replaced the load.

Top module: `ldu_stall_unit`

## Requirements
- R1: When `ex_is_load`=1, `id_reads_rs`=1 and decode IR[25:21] equals execute IR[20:16] (nonzero), `pc_hold` is 1 in that same cycle.
- R2: When `ex_is_load`=1, `id_reads_rt`=1 and decode IR[20:16] equals execute IR[20:16] (nonzero), `pc_hold` is 1 in that same cycle.
- R3: With `id_reads_rt`=0, a match on decode IR[20:16] causes no stall (I-type ALU writing rt).
- R4: A load whose destination field execute IR[20:16] is 0 never causes a stall.
- R5: When `ex_is_load`=0, no field match causes a stall.
- R6: The load's destination is taken from execute IR[20:16], never from execute IR[15:11]; a match on IR[15:11] alone gives no stall.
- R7: `pc_hold`, `ifid_hold` and `idex_bubble` always carry the same value.
- R8: A stall lasts exactly one cycle. After a cycle with `pc_hold`=1, the next cycle has `pc_hold`=0 even if the hazard inputs stay the same. The cycle after that may stall again.
- R9: While `rst`=1 (synchronous, active high) all three outputs are 0. The first cycle after reset can stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifid_ir | input | 32 | Instruction word in the fetch/decode register |
| idex_ir | input | 32 | Instruction word in the decode/execute register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| id_reads_rs | input | 1 | Decoding instruction reads its rs field |
| id_reads_rt | input | 1 | Decoding instruction reads its rt field |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a bubble (write enables cleared) into decode/execute |

## Verification
The operand-match logic is tried with a dependence through the first source only and through the second source only. Each case uses a different register number, so a swapped or missing comparator shows up. Near-miss patterns check that each gate suppresses a stall on its own. These are: a match on rt while rt is not read, a load into register 0, a non-load in execute, and a match against the execute word's rd field rather than rt. Further directed sequences keep one hazard applied for three cycles to confirm the one-cycle limit. They also apply a hazard during and right after reset.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int IR_W   = 32;
  localparam int REG_AW = 5;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/ldu_field_split.sv
module ldu_field_split #(
  parameter int IR_W   = ldu_pkg::IR_W,
  parameter int REG_AW = ldu_pkg::REG_AW,
  parameter int RS_LSB = ldu_pkg::RS_LSB,
  parameter int RT_LSB = ldu_pkg::RT_LSB
) (
  input  logic [IR_W-1:0]   ir,
  output logic [REG_AW-1:0] rs,
  output logic [REG_AW-1:0] rt
);
  assign rs = ir[RS_LSB +: REG_AW];
  assign rt = ir[RT_LSB +: REG_AW];
endmodule

// File: rtl/ldu_src_match.sv
module ldu_src_match #(
  parameter int REG_AW = ldu_pkg::REG_AW
) (
  input  logic [REG_AW-1:0] src,
  input  logic              src_used,
  input  logic [REG_AW-1:0] dst,
  input  logic              dst_live,
  output logic              hit
);
  assign hit = src_used && dst_live && (src == dst);
endmodule

// File: rtl/ldu_oneshot.sv
module ldu_oneshot (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic fire
);
  logic fired_q;

  assign fire = req && !fired_q && !rst;

  always_ff @(posedge clk) begin
    if (rst) fired_q <= 1'b0;
    else     fired_q <= fire;
  end
endmodule

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit #(
  parameter int IR_W    = ldu_pkg::IR_W,
  parameter int REG_AW  = ldu_pkg::REG_AW,
  parameter int RS_LSB  = ldu_pkg::RS_LSB,
  parameter int RT_LSB  = ldu_pkg::RT_LSB,
  parameter int NUM_SRC = ldu_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IR_W-1:0] ifid_ir,
  input  logic [IR_W-1:0] idex_ir,
  input  logic            ex_is_load,
  input  logic            id_reads_rs,
  input  logic            id_reads_rt,
  output logic            pc_hold,
  output logic            ifid_hold,
  output logic            idex_bubble
);
  logic [REG_AW-1:0] id_rs, id_rt, ex_rs, ex_rt;
  logic [REG_AW-1:0] src_sel [NUM_SRC];
  logic [NUM_SRC-1:0] src_use;
  logic [NUM_SRC-1:0] hit;
  logic dst_live, hazard, stall;
  logic unused_bits;

  ldu_field_split #(.IR_W(IR_W), .REG_AW(REG_AW), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB))
    u_id_split (.ir(ifid_ir), .rs(id_rs), .rt(id_rt));

  ldu_field_split #(.IR_W(IR_W), .REG_AW(REG_AW), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB))
    u_ex_split (.ir(idex_ir), .rs(ex_rs), .rt(ex_rt));

  assign unused_bits = ^{ifid_ir, idex_ir, ex_rs};

  assign src_sel[0] = id_rs;
  assign src_use[0] = id_reads_rs;
  assign src_sel[1] = id_rt;
  assign src_use[1] = id_reads_rt;

  // Register 0 is hard-wired, so a load into it produces no dependence.
  assign dst_live = ex_is_load && (ex_rt != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ldu_src_match #(.REG_AW(REG_AW)) u_match (
      .src(src_sel[g]), .src_used(src_use[g]),
      .dst(ex_rt), .dst_live(dst_live), .hit(hit[g]));
  end

  assign hazard = |hit;

  ldu_oneshot u_shot (.clk(clk), .rst(rst), .req(hazard), .fire(stall));

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/ldu_stall_chk.sv
module ldu_stall_chk #(
  parameter int IR_W   = ldu_pkg::IR_W,
  parameter int REG_AW = ldu_pkg::REG_AW,
  parameter int RS_LSB = ldu_pkg::RS_LSB,
  parameter int RT_LSB = ldu_pkg::RT_LSB,
  parameter int RD_LSB = ldu_pkg::RD_LSB
) (
  input logic            clk,
  input logic            rst,
  input logic [IR_W-1:0] ifid_ir,
  input logic [IR_W-1:0] idex_ir,
  input logic            ex_is_load,
  input logic            id_reads_rs,
  input logic            id_reads_rt,
  input logic            pc_hold
);
  logic [REG_AW-1:0] c_rs, c_rt, c_dst, c_rd;
  logic rs_m, rt_m;
  assign c_rs  = ifid_ir[RS_LSB +: REG_AW];
  assign c_rt  = ifid_ir[RT_LSB +: REG_AW];
  assign c_dst = idex_ir[RT_LSB +: REG_AW];
  assign c_rd  = idex_ir[RD_LSB +: REG_AW];
  assign rs_m  = id_reads_rs && (c_rs == c_dst);
  assign rt_m  = id_reads_rt && (c_rt == c_dst);

  AST_RS_STALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(pc_hold) && ex_is_load && c_dst != '0 && rs_m) |-> pc_hold); // R1
  AST_RT_STALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(pc_hold) && ex_is_load && c_dst != '0 && rt_m) |-> pc_hold); // R2
  AST_RT_UNREAD: assert property (@(posedge clk) disable iff (rst)
    (!id_reads_rt && !rs_m) |-> !pc_hold); // R3
  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    (c_dst == '0) |-> !pc_hold); // R4
  AST_NOT_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ex_is_load |-> !pc_hold); // R5
  AST_RD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!rs_m && !rt_m && (c_rs == c_rd || c_rt == c_rd)) |-> !pc_hold); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> !pc_hold); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |-> !pc_hold); // R9
endmodule

bind ldu_stall_unit ldu_stall_chk #(
  .IR_W(IR_W), .REG_AW(REG_AW), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB)
) u_chk (
  .clk(clk), .rst(rst), .ifid_ir(ifid_ir), .idex_ir(idex_ir),
  .ex_is_load(ex_is_load), .id_reads_rs(id_reads_rs),
  .id_reads_rt(id_reads_rt), .pc_hold(pc_hold)
);

// File: tb/ldu_stall_unit_tb.sv
`timescale 1ns/1ps
module ldu_stall_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] ifid_ir = '0;
  logic [31:0] idex_ir = '0;
  logic ex_is_load = 1'b0, id_reads_rs = 1'b0, id_reads_rt = 1'b0;
  logic pc_hold, ifid_hold, idex_bubble;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ldu_stall_unit u_dut (
    .clk(clk), .rst(rst), .ifid_ir(ifid_ir), .idex_ir(idex_ir),
    .ex_is_load(ex_is_load), .id_reads_rs(id_reads_rs), .id_reads_rt(id_reads_rt),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble));

  typedef struct packed {
    logic [3:0]  req;
    logic        ld;
    logic        rrs;
    logic        rrt;
    logic [31:0] exir;
    logic [31:0] idir;
    logic        exp;
  } vec_t;

  // load word: {6'h23, base, dest(rt), 16'h0}; R-type: {6'h00, rs, rt, rd/shamt/funct}
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b1, 1'b1, 1'b1, {6'h23, 5'd2, 5'd5, 16'h0},        {6'h00, 5'd5, 5'd7, 16'h2020},  1'b1}, // R1
    '{4'd2, 1'b1, 1'b1, 1'b1, {6'h23, 5'd2, 5'd9, 16'h0},        {6'h00, 5'd3, 5'd9, 16'h2020},  1'b1}, // R2
    '{4'd3, 1'b1, 1'b1, 1'b0, {6'h23, 5'd2, 5'd9, 16'h0},        {6'h08, 5'd3, 5'd9, 16'h0004},  1'b0}, // R3
    '{4'd4, 1'b1, 1'b1, 1'b1, {6'h23, 5'd2, 5'd0, 16'h0},        {6'h00, 5'd0, 5'd0, 16'h2020},  1'b0}, // R4
    '{4'd5, 1'b0, 1'b1, 1'b1, {6'h00, 5'd2, 5'd5, 16'h2020},     {6'h00, 5'd5, 5'd5, 16'h2020},  1'b0}, // R5
    '{4'd6, 1'b1, 1'b1, 1'b1, {6'h23, 5'd2, 5'd4, 5'd12, 11'h0}, {6'h00, 5'd12, 5'd13, 16'h2020}, 1'b0}, // R6
    '{4'd1, 1'b1, 1'b1, 1'b0, {6'h23, 5'd2, 5'd31, 16'h0},       {6'h08, 5'd31, 5'd6, 16'h0001}, 1'b1}, // R1
    '{4'd2, 1'b1, 1'b1, 1'b1, {6'h23, 5'd2, 5'd8, 16'h0},        {6'h00, 5'd8, 5'd8, 16'h2020},  1'b1}, // R2
    '{4'd1, 1'b1, 1'b0, 1'b1, {6'h23, 5'd2, 5'd10, 16'h0},       {6'h2b, 5'd10, 5'd11, 16'h0},   1'b0}  // R1 gate
  };

  // Every check also compares the three outputs with each other (R7).
  task automatic check(input string tag, input logic exp);
    checks++;
    if (pc_hold !== exp || ifid_hold !== exp || idex_bubble !== exp) begin
      fails++;
      $display("FAIL %s (R7 trio): pc_hold=%b ifid_hold=%b idex_bubble=%b expected %b",
               tag, pc_hold, ifid_hold, idex_bubble, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic rrs, input logic rrt,
                       input logic [31:0] exir, input logic [31:0] idir);
    ex_is_load = ld; id_reads_rs = rrs; id_reads_rt = rrt;
    idex_ir = exir; ifid_ir = idir;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  localparam logic [31:0] HZ_EX = {6'h23, 5'd1, 5'd3, 16'h0};
  localparam logic [31:0] HZ_ID = {6'h00, 5'd3, 5'd4, 16'h2020};

  initial begin
    // R9: hazard during reset stays silent
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, HZ_EX, HZ_ID);
    #1 check("R9 during reset", 1'b0);
    @(negedge clk);
    #1 check("R9 during reset held", 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1 check("R9 first cycle after reset", 1'b1);
    @(negedge clk);
    idle();
    #1 check("R5 idle", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].ld, VECS[i].rrs, VECS[i].rrt, VECS[i].exir, VECS[i].idir);
      #1;
      checks++;
      if (pc_hold !== VECS[i].exp || ifid_hold !== VECS[i].exp || idex_bubble !== VECS[i].exp) begin
        fails++;
        $display("FAIL vector %0d R%0d: pc_hold=%b ifid_hold=%b idex_bubble=%b expected %b",
                 i, VECS[i].req, pc_hold, ifid_hold, idex_bubble, VECS[i].exp);
      end
      @(negedge clk);
      idle();
    end

    // R8: one hazard held for three cycles -> 1, 0, 1
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, HZ_EX, HZ_ID);
    #1 check("R8 first cycle", 1'b1);
    @(negedge clk);
    #1 check("R8 second cycle suppressed", 1'b0);
    @(negedge clk);
    #1 check("R8 third cycle stalls again", 1'b1);

    // R9: reset in the middle clears the one-shot flag
    @(negedge clk);
    rst = 1'b1;
    #1 check("R9 reset mid-run", 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1 check("R9 after mid-run reset", 1'b1);
    @(negedge clk);
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: done=%b expected 1", done);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule